// File: doc/BRIEF.md
# Sync-Locked Video Test Pattern Generator

This block paints test images onto a 640 by 480 raster that runs from a 25 MHz pixel clock. Its only timing inputs are the horizontal and vertical sync pulses. It rebuilds the pixel column and line position from the edges of those pulses, so it needs no counter inputs. A 3-bit select code chooses one of several images: all black, a single flat primary, a checkerboard, or eight vertical bars that step through every combination of the three primaries. Each colour channel is 3 bits wide, which gives 512 possible colours, but every image here uses each channel either fully off or fully on.

Colour output comes out two clocks after the sync sample that set its position: one register holds the recovered coordinates and one holds the colour. The sync pulses pass through a matching two-stage delay, so a display sees sync and pixels in step. Any position outside the 640 by 480 visible window is painted black, whatever the select code says. The coordinate origin is the clock on which a sync input rises. Column 0 is the first clock with horizontal sync high, and line 0 is the line on which vertical sync rises.

Top module: `vid_test_pattern`

## Requirements
- R1: While reset is asserted, hsync_out, vsync_out, red, green and blue are all 0, whatever the inputs are.
- R2: hsync_out and vsync_out equal hsync_in and vsync_in as they were sampled two clocks earlier.
- R3: The column is 0 on the clock where hsync_in is first sampled high. It rises by one on each following clock, and without a new rising edge it wraps from 799 back to 0.
- R4: The line is 0 on the line where vsync_in rises. It rises by one on each further rising edge of hsync_in, and it wraps from 524 back to 0.
- R5: A pixel whose column is 640 or more, or whose line is 480 or more, is black (all channels 0) for every select code.
- R6: Select code 0 shows black over the whole frame. The unused codes 6 and 7 also show black.
- R7: Select codes 1, 2 and 3 make red, green or blue 3'b111 respectively, with the other two channels 0, across the visible window.
- R8: Select code 4 shows white (all channels 3'b111) where bit 5 of the column XOR bit 5 of the line is 1, and black where it is 0. This gives 32-pixel squares.
- R9: Select code 5 shows eight bars, each 80 columns wide. Bar i is the column divided by 80. Red is 3'b111 when bit 2 of i is set, green when bit 1 is set, and blue when bit 0 is set. Otherwise each channel is 0.
- R10: The colour on the outputs belongs to the pixel whose sync sample was taken two clocks earlier, so it lines up with the delayed syncs of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync_in | input | 1 | Horizontal sync pulse, active high |
| vsync_in | input | 1 | Vertical sync pulse, active high |
| pat_sel | input | 3 | Image select code |
| hsync_out | output | 1 | Horizontal sync delayed to match the colour |
| vsync_out | output | 1 | Vertical sync delayed to match the colour |
| red | output | 3 | Red channel |
| green | output | 3 | Green channel |
| blue | output | 3 | Blue channel |

## Verification
The assertions assume that vsync_in only rises on a clock where hsync_in also rises. They also assume that pat_sel stays steady for the two clocks a pixel spends in the pipeline. The stimulus meets both conditions: every vertical pulse starts together with a horizontal pulse, and the select code changes only between positioning runs. To reach distant lines quickly, the stimulus sends short 4-clock lines, which the block accepts because it only follows edges. Full 800-clock lines are used for the column wrap and the far columns.

// File: rtl/vtp_pkg.sv
package vtp_pkg;

    // Image select codes; values not listed here paint black.
    typedef enum logic [2:0] {
        PAT_BLACK   = 3'd0,
        PAT_RED     = 3'd1,
        PAT_GREEN   = 3'd2,
        PAT_BLUE    = 3'd3,
        PAT_CHECKER = 3'd4,
        PAT_BARS    = 3'd5
    } pat_e;

endpackage

// File: rtl/vtp_coord_track.sv
// Rebuilds column and line position from the edges of the sync inputs.
module vtp_coord_track #(
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525,
    parameter int CW      = $clog2(H_TOTAL),
    parameter int RW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hsync_in,
    input  logic          vsync_in,
    output logic [CW-1:0] col,
    output logic [RW-1:0] row
);
    localparam logic [CW-1:0] COL_LAST = CW'(H_TOTAL - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(V_TOTAL - 1);

    logic hs_q, vs_q;
    logic h_rise, v_rise;

    assign h_rise = hsync_in & ~hs_q;
    assign v_rise = vsync_in & ~vs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync_in;
            vs_q <= vsync_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col <= '0;
        end else if (h_rise || col == COL_LAST) begin
            col <= '0;
        end else begin
            col <= col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
        end else if (v_rise) begin
            row <= '0;
        end else if (h_rise) begin
            row <= (row == ROW_LAST) ? '0 : row + 1'b1;
        end
    end

endmodule

// File: rtl/vtp_pixel_gen.sv
// Chooses the colour for one coordinate and registers it.
module vtp_pixel_gen
    import vtp_pkg::*;
#(
    parameter int H_VIS   = 640,
    parameter int V_VIS   = 480,
    parameter int CH_W    = 3,
    parameter int CHK_BIT = 5,
    parameter int CW      = 10,
    parameter int RW      = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2:0]      pat_sel,
    input  logic [CW-1:0]   col,
    input  logic [RW-1:0]   row,
    output logic [CH_W-1:0] red,
    output logic [CH_W-1:0] green,
    output logic [CH_W-1:0] blue
);
    localparam int              NUM_BARS = 8;
    localparam int              BIW      = $clog2(NUM_BARS);
    localparam int              BAR_W    = H_VIS / NUM_BARS;
    localparam logic [CH_W-1:0] FULL     = {CH_W{1'b1}};

    logic [BIW-1:0]  bar_idx;
    logic            check_on;
    logic            visible;
    logic [CH_W-1:0] r_n, g_n, b_n;

    always_comb begin
        bar_idx = '0;
        for (int k = 1; k < NUM_BARS; k++) begin
            if (col >= CW'(k * BAR_W)) bar_idx = BIW'(k);
        end
        check_on = col[CHK_BIT] ^ row[CHK_BIT];
        visible  = (col < CW'(H_VIS)) && (row < RW'(V_VIS));
        r_n = '0;
        g_n = '0;
        b_n = '0;
        if (visible) begin
            unique case (pat_e'(pat_sel))
                PAT_RED:   r_n = FULL;
                PAT_GREEN: g_n = FULL;
                PAT_BLUE:  b_n = FULL;
                PAT_CHECKER: begin
                    if (check_on) begin
                        r_n = FULL;
                        g_n = FULL;
                        b_n = FULL;
                    end
                end
                PAT_BARS: begin
                    r_n = {CH_W{bar_idx[2]}};
                    g_n = {CH_W{bar_idx[1]}};
                    b_n = {CH_W{bar_idx[0]}};
                end
                default: begin
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            red   <= '0;
            green <= '0;
            blue  <= '0;
        end else begin
            red   <= r_n;
            green <= g_n;
            blue  <= b_n;
        end
    end

endmodule

// File: rtl/vtp_sync_delay.sv
// Register chain that keeps the sync pulses in step with the colour path.
module vtp_sync_delay #(
    parameter int WIDTH = 2,
    parameter int DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage[g] <= '0;
            end else if (g == 0) begin
                stage[g] <= d;
            end else begin
                stage[g] <= stage[(g == 0) ? 0 : g - 1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/vid_test_pattern.sv
module vid_test_pattern #(
    parameter int H_TOTAL = 800,
    parameter int V_TOTAL = 525,
    parameter int H_VIS   = 640,
    parameter int V_VIS   = 480,
    parameter int CH_W    = 3,
    parameter int CHK_BIT = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hsync_in,
    input  logic            vsync_in,
    input  logic [2:0]      pat_sel,
    output logic            hsync_out,
    output logic            vsync_out,
    output logic [CH_W-1:0] red,
    output logic [CH_W-1:0] green,
    output logic [CH_W-1:0] blue
);
    localparam int CW   = $clog2(H_TOTAL);
    localparam int RW   = $clog2(V_TOTAL);
    localparam int PIPE = 2;   // coordinate register + colour register

    logic [CW-1:0] pix_col;
    logic [RW-1:0] pix_row;
    logic [1:0]    sync_q;

    vtp_coord_track #(
        .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .CW(CW), .RW(RW)
    ) u_track (
        .clk(clk), .rst_n(rst_n),
        .hsync_in(hsync_in), .vsync_in(vsync_in),
        .col(pix_col), .row(pix_row)
    );

    vtp_pixel_gen #(
        .H_VIS(H_VIS), .V_VIS(V_VIS), .CH_W(CH_W),
        .CHK_BIT(CHK_BIT), .CW(CW), .RW(RW)
    ) u_pix (
        .clk(clk), .rst_n(rst_n), .pat_sel(pat_sel),
        .col(pix_col), .row(pix_row),
        .red(red), .green(green), .blue(blue)
    );

    vtp_sync_delay #(.WIDTH(2), .DEPTH(PIPE)) u_sdly (
        .clk(clk), .rst_n(rst_n),
        .d({vsync_in, hsync_in}), .q(sync_q)
    );

    assign hsync_out = sync_q[0];
    assign vsync_out = sync_q[1];

endmodule

// File: rtl/vtp_checker.sv
module vtp_checker #(
    parameter int H_TOTAL = 800,
    parameter int H_VIS   = 640,
    parameter int V_VIS   = 480,
    parameter int CH_W    = 3,
    parameter int CW      = 10,
    parameter int RW      = 10
) (
    input logic            clk,
    input logic            rst_n,
    input logic            hsync_in,
    input logic            vsync_in,
    input logic            hsync_out,
    input logic            vsync_out,
    input logic [CH_W-1:0] red,
    input logic [CH_W-1:0] green,
    input logic [CH_W-1:0] blue,
    input logic [CW-1:0]   col,
    input logic [RW-1:0]   row
);
    localparam logic [CH_W-1:0] FULL = {CH_W{1'b1}};

    logic [1:0] cyc;
    logic       cyc_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= '0;
        else if (cyc != 2'd2) cyc <= cyc + 1'b1;
    end
    assign cyc_ok = (cyc == 2'd2);

    // R2
    sync_dly_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_ok |-> (hsync_out == $past(hsync_in, 2) && vsync_out == $past(vsync_in, 2)));

    // R3
    col_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ok && $rose(hsync_in)) |=> (col == '0));

    // R3
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ok && !$rose(hsync_in) && col != CW'(H_TOTAL - 1)) |=> (col == CW'($past(col) + 1'b1)));

    // R3
    col_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ok && !$rose(hsync_in) && col == CW'(H_TOTAL - 1)) |=> (col == '0));

    // R4
    row_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ok && $rose(vsync_in)) |=> (row == '0));

    // R5
    blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_ok && (col >= CW'(H_VIS) || row >= RW'(V_VIS))) |=> ({red, green, blue} == '0));

    // R7
    level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (red == '0 || red == FULL) && (green == '0 || green == FULL) && (blue == '0 || blue == FULL));

endmodule

bind vid_test_pattern vtp_checker #(
    .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .V_VIS(V_VIS),
    .CH_W(CH_W), .CW(CW), .RW(RW)
) u_vtp_chk (
    .clk(clk), .rst_n(rst_n),
    .hsync_in(hsync_in), .vsync_in(vsync_in),
    .hsync_out(hsync_out), .vsync_out(vsync_out),
    .red(red), .green(green), .blue(blue),
    .col(pix_col), .row(pix_row)
);

// File: tb/sim_vid_test_pattern.sv
module sim_vid_test_pattern;
    localparam int PERIOD = 40;   // 25 MHz
    localparam int NV     = 26;

    typedef struct packed {
        logic [3:0] req;
        logic [2:0] sel;
        logic [9:0] h;
        logic [9:0] v;
        logic [2:0] r;
        logic [2:0] g;
        logic [2:0] b;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{4'd6, 3'd0, 10'd100, 10'd100, 3'd0, 3'd0, 3'd0},   // R6 black
        '{4'd7, 3'd1, 10'd0,   10'd0,   3'd7, 3'd0, 3'd0},   // R7 red origin
        '{4'd7, 3'd1, 10'd639, 10'd479, 3'd7, 3'd0, 3'd0},   // R7 red last pixel
        '{4'd5, 3'd1, 10'd640, 10'd10,  3'd0, 3'd0, 3'd0},   // R5 first blank column
        '{4'd7, 3'd2, 10'd320, 10'd200, 3'd0, 3'd7, 3'd0},   // R7 green
        '{4'd5, 3'd2, 10'd320, 10'd480, 3'd0, 3'd0, 3'd0},   // R5 first blank line
        '{4'd7, 3'd3, 10'd5,   10'd470, 3'd0, 3'd0, 3'd7},   // R7 blue
        '{4'd5, 3'd3, 10'd799, 10'd5,   3'd0, 3'd0, 3'd0},   // R5 last column
        '{4'd8, 3'd4, 10'd40,  10'd0,   3'd7, 3'd7, 3'd7},   // R8
        '{4'd8, 3'd4, 10'd40,  10'd40,  3'd0, 3'd0, 3'd0},   // R8
        '{4'd8, 3'd4, 10'd10,  10'd33,  3'd7, 3'd7, 3'd7},   // R8
        '{4'd8, 3'd4, 10'd31,  10'd0,   3'd0, 3'd0, 3'd0},   // R8 square edge
        '{4'd8, 3'd4, 10'd32,  10'd0,   3'd7, 3'd7, 3'd7},   // R8 square edge
        '{4'd8, 3'd4, 10'd639, 10'd479, 3'd7, 3'd7, 3'd7},   // R8 corner
        '{4'd5, 3'd4, 10'd700, 10'd100, 3'd0, 3'd0, 3'd0},   // R5
        '{4'd5, 3'd4, 10'd200, 10'd500, 3'd0, 3'd0, 3'd0},   // R5
        '{4'd9, 3'd5, 10'd0,   10'd0,   3'd0, 3'd0, 3'd0},   // R9 bar 0
        '{4'd9, 3'd5, 10'd79,  10'd1,   3'd0, 3'd0, 3'd0},   // R9 bar 0 edge
        '{4'd9, 3'd5, 10'd80,  10'd1,   3'd0, 3'd0, 3'd7},   // R9 bar 1 edge
        '{4'd9, 3'd5, 10'd250, 10'd50,  3'd0, 3'd7, 3'd7},   // R9 bar 3
        '{4'd9, 3'd5, 10'd420, 10'd300, 3'd7, 3'd0, 3'd7},   // R9 bar 5
        '{4'd9, 3'd5, 10'd500, 10'd300, 3'd7, 3'd7, 3'd0},   // R9 bar 6
        '{4'd9, 3'd5, 10'd639, 10'd479, 3'd7, 3'd7, 3'd7},   // R9 bar 7
        '{4'd5, 3'd5, 10'd640, 10'd300, 3'd0, 3'd0, 3'd0},   // R5
        '{4'd6, 3'd6, 10'd100, 10'd100, 3'd0, 3'd0, 3'd0},   // R6 unused code
        '{4'd6, 3'd7, 10'd300, 10'd200, 3'd0, 3'd0, 3'd0}    // R6 unused code
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       hs_i, vs_i;
    logic [2:0] sel;
    logic       hs_o, vs_o;
    logic [2:0] red, green, blue;
    int         n_tests = 0;
    int         n_fail  = 0;
    logic       done    = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    vid_test_pattern u0 (
        .clk(clk), .rst_n(rst_n),
        .hsync_in(hs_i), .vsync_in(vs_i), .pat_sel(sel),
        .hsync_out(hs_o), .vsync_out(vs_o),
        .red(red), .green(green), .blue(blue)
    );

    task automatic check_bits(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Positions the recovered coordinate at line v, column h, then waits
    // until the colour for that input sample is on the outputs.
    task automatic run_to(input int h, input int v);
        int len;
        for (int c = 0; c < 2; c++) begin
            @(negedge clk); hs_i = 1'b0; vs_i = 1'b0;
        end
        for (int i = 0; i <= v; i++) begin
            len = (i == v) ? h + 2 : 4;
            for (int c = 0; c < len; c++) begin
                @(negedge clk);
                hs_i = (c < 2);
                vs_i = (i == 0) && (c < 2);
            end
        end
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 190000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        hs_i  = 1'b1;
        vs_i  = 1'b1;
        sel   = 3'd1;
        repeat (4) @(negedge clk);
        // R1: outputs stay low while reset is held
        check_bits("R1", {4'b0, hs_o, vs_o, red[2:0]}, 9'd0);
        check_bits("R1", {green, blue, 3'b0}, 9'd0);
        hs_i = 1'b0;
        vs_i = 1'b0;
        sel  = 3'd0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R2: sync pulse appears two clocks later
        hs_i = 1'b1; vs_i = 1'b1;
        @(negedge clk);
        check_bits("R2", {7'b0, hs_o, vs_o}, 9'd0);
        hs_i = 1'b0; vs_i = 1'b0;
        @(negedge clk);
        check_bits("R2", {7'b0, hs_o, vs_o}, 9'd3);
        @(negedge clk);
        check_bits("R2", {7'b0, hs_o, vs_o}, 9'd0);

        // Table of positions and expected colours (R5..R10)
        for (int n = 0; n < NV; n++) begin
            sel = VEC[n].sel;
            run_to(int'(VEC[n].h), int'(VEC[n].v));
            check_bits($sformatf("R%0d/R10 vec %0d", VEC[n].req, n),
                       {red, green, blue}, {VEC[n].r, VEC[n].g, VEC[n].b});
        end

        // R3: column wraps after 799 with no further sync edge; col 840 -> 40
        sel = 3'd4;
        run_to(840, 0);
        check_bits("R3 col wrap", {red, green, blue}, 9'h1FF);

        // R4: line count wraps after 524; line 528 -> 3, col 100 -> white
        run_to(100, 528);
        check_bits("R4 row wrap", {red, green, blue}, 9'h1FF);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule